// File: doc/BRIEF.md
# Vectored interrupt sequencer

This block arbitrates five interrupt sources of a small 8-bit processor: two external pins, two timer overflow flags and a serial flag. Requests are captured only on cycles where the core asserts its late-phase sampling strobe, once per machine cycle. An 8-bit enable register holds a global gate and one gate per source. When the core signals that an instruction has finished and a gated request is pending, the block pulses a take output. In the same cycle it presents a fixed 16-bit vector, so the core can push its return address and jump.

Once a take has been issued, the block treats the service as in progress and accepts nothing more. This lasts until the core reports the return-from-interrupt strobe, which re-arms acceptance. External requests are edge-detected. Timer requests clear themselves when their vector is taken. The serial request follows its flag level and stays pending until software clears the flag.

Top module: `irq_vector_seq`

## Requirements
- R1: After reset, take_o is 0, vec_o is 0x0000, the enable register reads as all zeros and no take occurs until it is written.
- R2: Each source has its own vector: external pin 0 gives 0x0003, timer 0 0x000B, external pin 1 0x0013, timer 1 0x001B, serial 0x0023 (base 3, stride 8). vec_o changes only in a cycle with take_o high.
- R3: Enable write data bit 7 is a global gate. Bits 0..4 gate external 0, timer 0, external 1, timer 1 and serial. A request whose gate is closed is never taken, but it stays pending and is taken once the gate opens (0x82 opens timer 0 only; 0x85 opens both external pins).
- R4: A take happens only at an instruction boundary. take_o is a one-cycle pulse in the cycle after the clock edge at which insn_done_i was high with a gated request pending.
- R5: When several gated requests are pending, the one with the lowest vector address is taken first.
- R6: After a take, no further take occurs until ret_i has been seen high at a clock edge. The next boundary after that may take again.
- R7: Request inputs are captured only at clock edges where sample_stb_i is high. A timer flag that rises and falls between strobes is not seen.
- R8: An external pin raises a request on a low-to-high change between two successive strobes. A pin held high raises only one request.
- R9: The pending request of an external pin or timer is cleared when its vector is taken.
- R10: The serial request follows ser_flag_i at each strobe and is not cleared by a take. If the flag is still set after the return, it is taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0_pin_i | input | 1 | External request pin 0 |
| ext1_pin_i | input | 1 | External request pin 1 |
| tmr0_ovf_i | input | 1 | Timer 0 overflow flag |
| tmr1_ovf_i | input | 1 | Timer 1 overflow flag |
| ser_flag_i | input | 1 | Serial port request flag |
| sample_stb_i | input | 1 | Late-phase sampling strobe, once per machine cycle |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| insn_done_i | input | 1 | Instruction boundary strobe |
| ret_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | One-cycle take pulse |
| vec_o | output | 16 | Vector address of the last take |
| in_service_o | output | 1 | Service in progress |

## Verification
The bench goes after simultaneous pending requests across the enable gates. A wrong priority encoder would jump to timer 1 or serial ahead of external pin 1. It holds an external pin high across many strobes: a level-sensitive design would take it over and over. It pulses a timer flag between strobes, which a design sampling every cycle would catch. It raises new requests while a service is open, where a missing busy state would nest interrupts. It also keeps the serial flag set through a return, which a design that cleared it on take would fail to take a second time.

// File: rtl/irq_vector_seq.sv
module irq_vector_seq #(
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int ADDR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext0_pin_i,
  input  logic              ext1_pin_i,
  input  logic              tmr0_ovf_i,
  input  logic              tmr1_ovf_i,
  input  logic              ser_flag_i,
  input  logic              sample_stb_i,
  input  logic              en_we_i,
  input  logic [7:0]        en_wdata_i,
  input  logic              insn_done_i,
  input  logic              ret_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              in_service_o
);
  localparam int NSRC = 5;
  localparam int SER  = NSRC - 1;

  logic [7:0]        en_q;
  logic [NSRC-1:0]   pend_q;
  logic [1:0]        pin_q;
  logic              busy_q;
  logic              take_q;
  logic [ADDR_W-1:0] vec_q;

  logic [NSRC-1:0] set_v, elig, win, clr;
  logic [2:0]      win_idx;
  logic            go;

  assign set_v[0] = sample_stb_i & ext0_pin_i & ~pin_q[0];
  assign set_v[1] = sample_stb_i & tmr0_ovf_i;
  assign set_v[2] = sample_stb_i & ext1_pin_i & ~pin_q[1];
  assign set_v[3] = sample_stb_i & tmr1_ovf_i;
  assign set_v[4] = 1'b0;

  assign elig = pend_q & en_q[NSRC-1:0] & {NSRC{en_q[7]}};
  assign win  = elig & (~elig + 1'b1);
  assign go   = insn_done_i & ~busy_q & (|elig);
  assign clr  = go ? (win & ~(NSRC'(1) << SER)) : '0;

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (win[i]) win_idx = 3'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      pin_q  <= '0;
      busy_q <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (en_we_i) en_q <= en_wdata_i;
      if (sample_stb_i) begin
        pin_q       <= {ext1_pin_i, ext0_pin_i};
        pend_q[SER] <= ser_flag_i;
      end
      pend_q[SER-1:0] <= (pend_q[SER-1:0] & ~clr[SER-1:0]) | set_v[SER-1:0];
      take_q <= go;
      if (go) begin
        busy_q <= 1'b1;
        vec_q  <= ADDR_W'(VEC_BASE + VEC_STRIDE * int'(win_idx));
      end else if (ret_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign take_o       = take_q;
  assign vec_o        = vec_q;
  assign in_service_o = busy_q;

  p_take_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $past(insn_done_i));

  p_hold_until_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ret_i) |=> (busy_q && !take_q));

  p_vec_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !take_q |-> $stable(vec_q));

  p_vec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (vec_q == ADDR_W'(VEC_BASE) || vec_q == ADDR_W'(VEC_BASE + VEC_STRIDE) ||
                vec_q == ADDR_W'(VEC_BASE + 2*VEC_STRIDE) || vec_q == ADDR_W'(VEC_BASE + 3*VEC_STRIDE) ||
                vec_q == ADDR_W'(VEC_BASE + 4*VEC_STRIDE)));

  p_global_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $past(en_q[7]));

  p_win_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));
endmodule

// File: tb/irq_vector_seq_bench.sv
module irq_vector_seq_bench;
  logic clk = 0, rst_n = 0;
  logic ext0 = 0, ext1 = 0, tmr0 = 0, tmr1 = 0, ser = 0, stb = 0;
  logic en_we = 0, insn_done = 0, ret = 0;
  logic [7:0] en_wdata = 0;
  logic take;
  logic [15:0] vec;
  logic insvc;

  always #2 clk = ~clk;

  irq_vector_seq u_irq_vector_seq (
    .clk(clk), .rst_n(rst_n), .ext0_pin_i(ext0), .ext1_pin_i(ext1),
    .tmr0_ovf_i(tmr0), .tmr1_ovf_i(tmr1), .ser_flag_i(ser), .sample_stb_i(stb),
    .en_we_i(en_we), .en_wdata_i(en_wdata), .insn_done_i(insn_done), .ret_i(ret),
    .take_o(take), .vec_o(vec), .in_service_o(insvc));

  int n_chk = 0, n_fail = 0, cyc_n = 0, n_take = 0;
  int last_vec = 0;
  string cur = "R1";

  // behavioural reference
  int m_pend[5];
  int m_prev[2];
  int m_en = 0, m_busy = 0, m_take = 0, m_vec = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int elig, pick, nt;
    int np[5];
    if (!rst_n) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      m_prev[0] = 0; m_prev[1] = 0;
      m_en = 0; m_busy = 0; m_take = 0; m_vec = 0;
    end else begin
      pick = -1;
      for (int i = 0; i < 5; i++)
        if (pick < 0 && m_pend[i] != 0 && ((m_en >> i) & 1) != 0 && ((m_en >> 7) & 1) != 0) pick = i;
      elig = (pick >= 0);
      nt = (insn_done && !m_busy && elig) ? 1 : 0;
      foreach (np[i]) np[i] = m_pend[i];
      if (nt && pick < 4) np[pick] = 0;
      if (stb) begin
        if (ext0 && !m_prev[0]) np[0] = 1;
        if (tmr0) np[1] = 1;
        if (ext1 && !m_prev[1]) np[2] = 1;
        if (tmr1) np[3] = 1;
        np[4] = ser;
        m_prev[0] = ext0; m_prev[1] = ext1;
      end
      foreach (np[i]) m_pend[i] = np[i];
      if (nt) begin m_busy = 1; m_vec = 3 + 8 * pick; end
      else if (ret) m_busy = 0;
      m_take = nt;
      if (en_we) m_en = en_wdata;
    end
  end

  always @(negedge clk) begin
    cyc_n++;
    if (rst_n) begin
      chk({cur, " take"}, int'(take), m_take);
      chk({cur, " vec"}, int'(vec), m_vec);
      if (take) begin n_take++; last_vec = int'(vec); end
    end
    stb <= (cyc_n % 4 == 3);
    if (cyc_n > 50000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected <50000", cyc_n);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr_en(logic [7:0] d); en_we = 1; en_wdata = d; cyc(1); en_we = 0; endtask
  task automatic boundary(); insn_done = 1; cyc(1); insn_done = 0; cyc(2); endtask
  task automatic do_ret(); ret = 1; cyc(1); ret = 0; cyc(1); endtask

  task automatic raise(int k);
    case (k)
      0: begin ext0 = 1; cyc(4); ext0 = 0; end
      1: begin tmr0 = 1; cyc(4); tmr0 = 0; end
      2: begin ext1 = 1; cyc(4); ext1 = 0; end
      3: begin tmr1 = 1; cyc(4); tmr1 = 0; end
      default: begin ser = 1; cyc(4); end
    endcase
  endtask

  initial begin
    int t0;
    cyc(3);
    chk("R1 take in reset", int'(take), 0);
    chk("R1 vec in reset", int'(vec), 0);
    rst_n = 1;
    cyc(2);
    cur = "R1";
    raise(1); boundary();
    chk("R1 no take before enable", n_take, 0);
    wr_en(8'h00); cyc(1);

    cur = "R2";
    for (int k = 0; k < 5; k++) begin
      wr_en(8'h80 | (8'h01 << k));
      t0 = n_take;
      raise(k); boundary();
      chk("R2 one take", n_take - t0, 1);
      chk("R2 vector", last_vec, 3 + 8 * k);
      ser = 0; cyc(5);
      do_ret();
    end

    cur = "R3";
    wr_en(8'h02); t0 = n_take;
    raise(1); boundary(); boundary();
    chk("R3 global gate closed", n_take - t0, 0);
    wr_en(8'h85); boundary();
    chk("R3 0x85 leaves timer0 gated", n_take - t0, 0);
    wr_en(8'h82); boundary();
    chk("R3 pending taken after gate opens", n_take - t0, 1);
    chk("R3 vector", last_vec, 'h0B);
    do_ret();

    cur = "R4";
    wr_en(8'h81); t0 = n_take;
    raise(0); cyc(6);
    chk("R4 no take without boundary", n_take - t0, 0);
    boundary();
    chk("R4 take at boundary", n_take - t0, 1);
    do_ret();

    cur = "R5";
    wr_en(8'h9F); t0 = n_take;
    ser = 1; tmr1 = 1; ext1 = 1; cyc(4); tmr1 = 0; ext1 = 0; cyc(1);
    boundary();
    chk("R5 first winner", last_vec, 'h13);
    do_ret(); boundary();
    chk("R5 second winner", last_vec, 'h1B);
    do_ret(); boundary();
    chk("R5 third winner", last_vec, 'h23);
    chk("R5 take count", n_take - t0, 3);

    cur = "R10";
    do_ret(); boundary();
    chk("R10 serial retaken after return", last_vec, 'h23);
    chk("R10 count", n_take - t0, 4);
    ser = 0; cyc(5); do_ret(); boundary();
    chk("R10 no take once flag cleared", n_take - t0, 4);

    cur = "R6";
    wr_en(8'h83); t0 = n_take;
    raise(0); boundary();
    chk("R6 first take", n_take - t0, 1);
    raise(1); boundary(); boundary();
    chk("R6 nothing while in service", n_take - t0, 1);
    chk("R6 in service flag", int'(insvc), 1);
    do_ret(); boundary();
    chk("R6 take after return", n_take - t0, 2);
    chk("R6 vector", last_vec, 'h0B);
    do_ret();

    cur = "R7";
    wr_en(8'h82); t0 = n_take;
    while (cyc_n % 4 != 0) cyc(1);
    tmr0 = 1; cyc(1); tmr0 = 0; cyc(4);
    boundary();
    chk("R7 flag between strobes ignored", n_take - t0, 0);

    cur = "R8";
    wr_en(8'h81); t0 = n_take;
    ext0 = 1; cyc(5); boundary(); do_ret();
    cyc(8); boundary(); do_ret(); boundary();
    chk("R8 held pin gives one take", n_take - t0, 1);
    ext0 = 0; cyc(5);

    cur = "R9";
    wr_en(8'h88); t0 = n_take;
    raise(3); boundary(); do_ret(); boundary(); boundary();
    chk("R9 timer request cleared by take", n_take - t0, 1);
    wr_en(8'h84); raise(2); boundary(); do_ret(); boundary();
    chk("R9 pin request cleared by take", n_take - t0, 2);

    cyc(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule